// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor datapath that runs each instruction as a series of short steps. The datapath has one memory for both instructions and data and a single ALU. On every clock edge the sequencer moves through a fixed set of nine steps and drives the datapath's enables and multiplexer selects. Because each step takes one cycle, different instructions take different numbers of cycles. Four instruction classes are supported: register-to-register ALU operations, word load, word store and branch when equal.

The controller is a Moore machine, so every control line depends only on the current step. The one exception is the combined program-counter write enable. That enable is built inside the block from the unconditional PC update, the conditional PC update and the ALU's zero flag. The opcode is read only in the decode step and the address step. An opcode the block does not recognise ends the instruction after decode and raises a flag for one cycle.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset `rst` puts the block in the fetch step and clears `bad_op`. The first cycle after reset is released shows the fetch controls.
- R2: Fetch drives `mem_rd`=1, `ir_we`=1, `pc_upd`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=1, `alu_op`=0 and `pc_src`=0. The next step is always decode.
- R3: Decode drives `alu_a_sel`=0, `alu_b_sel`=3 and `alu_op`=0 with no enable set. It then dispatches on `opcode`: 6'b100011 (load) and 6'b101011 (store) go to address, 6'b000000 (register op) goes to execute, and 6'b000100 (branch) goes to branch completion.
- R4: The address step drives `alu_a_sel`=1, `alu_b_sel`=2 and `alu_op`=0. It continues to load read for a load and to store write for a store.
- R5: Load read drives `mem_rd`=1 with `addr_sel`=1. Load write-back follows with `reg_we`=1, `dst_sel`=0 and `wb_sel`=1, and then fetch.
- R6: Store write drives `mem_wr`=1 with `addr_sel`=1, and then fetch.
- R7: Execute drives `alu_a_sel`=1, `alu_b_sel`=0 and `alu_op`=2. Register write-back follows with `reg_we`=1, `dst_sel`=1 and `wb_sel`=0, and then fetch.
- R8: Branch completion drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1, `pc_upd_cond`=1 and `pc_src`=1, and then fetch.
- R9: Counted from one fetch to the next, a load takes 5 cycles, a store 4, a register op 4 and a branch 3.
- R10: Every control output not named for a step is 0 in that step. `mem_rd` and `mem_wr` are never both 1.
- R11: An unrecognised opcode in decode returns the block to fetch, so the instruction takes 2 cycles. `bad_op` is 1 during exactly that following fetch cycle and 0 at all other times.
- R12: `pc_we` equals `pc_upd` OR (`pc_upd_cond` AND `zero`). In steps where both update lines are 0, `zero` has no effect on `pc_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address source: 0 is PC, 1 is ALU output register |
| ir_we | output | 1 | Instruction register write enable |
| reg_we | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register field select: 1 selects the register-op destination |
| wb_sel | output | 1 | Write-back data select: 1 is memory data, 0 is ALU output |
| alu_a_sel | output | 1 | ALU first operand: 0 is PC, 1 is register A |
| alu_b_sel | output | 2 | ALU second operand: 0 register B, 1 constant 4, 2 immediate, 3 shifted immediate |
| alu_op | output | 2 | ALU operation class: 0 add, 1 subtract, 2 function field |
| pc_upd | output | 1 | Unconditional PC update |
| pc_upd_cond | output | 1 | PC update when the zero flag is set |
| pc_src | output | 1 | PC source: 0 is ALU result, 1 is ALU output register |
| pc_we | output | 1 | Combined PC write enable |
| bad_op | output | 1 | One-cycle unrecognised-opcode flag |

## Verification
The dispatch properties assume that `opcode` holds steady from decode to the end of the instruction, as an instruction register would hold it. The stimulus changes `opcode` only during a fetch cycle. Both `zero` and `rst` are free inputs. The stimulus redraws `zero` every cycle and applies one reset in the middle of a load. Opcodes come from a directed opening sequence, then from a random mix that includes values outside the four known encodings.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPC_W  = 6;
  localparam int NUM_ST = 9;
  localparam int ST_W   = $clog2(NUM_ST);

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LDRD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STWR   = 4'd5,
    S_REXE   = 4'd6,
    S_RWB    = 4'd7,
    S_BEQ    = 4'd8
  } mcc_state_e;

  typedef enum logic [2:0] {
    C_RTYPE,
    C_LOAD,
    C_STORE,
    C_BEQ,
    C_BAD
  } op_class_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_we;
    logic       reg_we;
    logic       dst_sel;
    logic       wb_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       pc_upd;
    logic       pc_upd_cond;
    logic       pc_src;
  } mcc_ctl_t;

  // ALU second-operand and operation codes
  localparam logic [1:0] BSEL_REG = 2'd0;
  localparam logic [1:0] BSEL_FOUR = 2'd1;
  localparam logic [1:0] BSEL_IMM = 2'd2;
  localparam logic [1:0] BSEL_IMMSH = 2'd3;
  localparam logic [1:0] AOP_ADD = 2'd0;
  localparam logic [1:0] AOP_SUB = 2'd1;
  localparam logic [1:0] AOP_FUNC = 2'd2;

  // Step after the current one, given the class of the held opcode
  function automatic mcc_state_e next_step(mcc_state_e s, op_class_e c);
    mcc_state_e n;
    case (s)
      S_FETCH:  n = S_DECODE;
      S_DECODE: begin
        case (c)
          C_LOAD, C_STORE: n = S_ADDR;
          C_RTYPE:         n = S_REXE;
          C_BEQ:           n = S_BEQ;
          default:         n = S_FETCH;
        endcase
      end
      S_ADDR:   n = (c == C_LOAD) ? S_LDRD : S_STWR;
      S_LDRD:   n = S_LDWB;
      S_REXE:   n = S_RWB;
      default:  n = S_FETCH;
    endcase
    return n;
  endfunction

  // Control word of a step; every field not set here is zero
  function automatic mcc_ctl_t ctl_of(mcc_state_e s);
    mcc_ctl_t w;
    w = '0;
    case (s)
      S_FETCH: begin
        w.mem_rd    = 1'b1;
        w.ir_we     = 1'b1;
        w.alu_b_sel = BSEL_FOUR;
        w.pc_upd    = 1'b1;
      end
      S_DECODE: w.alu_b_sel = BSEL_IMMSH;
      S_ADDR: begin
        w.alu_a_sel = 1'b1;
        w.alu_b_sel = BSEL_IMM;
      end
      S_LDRD: begin
        w.mem_rd   = 1'b1;
        w.addr_sel = 1'b1;
      end
      S_LDWB: begin
        w.reg_we = 1'b1;
        w.wb_sel = 1'b1;
      end
      S_STWR: begin
        w.mem_wr   = 1'b1;
        w.addr_sel = 1'b1;
      end
      S_REXE: begin
        w.alu_a_sel = 1'b1;
        w.alu_op    = AOP_FUNC;
      end
      S_RWB: begin
        w.reg_we  = 1'b1;
        w.dst_sel = 1'b1;
      end
      S_BEQ: begin
        w.alu_a_sel   = 1'b1;
        w.alu_op      = AOP_SUB;
        w.pc_upd_cond = 1'b1;
        w.pc_src      = 1'b1;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic pc_enable(logic upd, logic upd_cond, logic z);
    return upd | (upd_cond & z);
  endfunction

endpackage

// File: rtl/mcc_opdecode.sv
module mcc_opdecode
  import mcc_pkg::*;
#(
  parameter int                OW        = 6,
  parameter logic [OW-1:0]     OPC_RTYPE = 6'b000000,
  parameter logic [OW-1:0]     OPC_LOAD  = 6'b100011,
  parameter logic [OW-1:0]     OPC_STORE = 6'b101011,
  parameter logic [OW-1:0]     OPC_BEQ   = 6'b000100
) (
  input  logic [OW-1:0] opcode,
  output op_class_e     cls
);

  always_comb begin
    if (opcode == OPC_RTYPE)      cls = C_RTYPE;
    else if (opcode == OPC_LOAD)  cls = C_LOAD;
    else if (opcode == OPC_STORE) cls = C_STORE;
    else if (opcode == OPC_BEQ)   cls = C_BEQ;
    else                          cls = C_BAD;
  end

endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  op_class_e  cls,
  output mcc_state_e state,
  output logic       bad_op
);

  mcc_state_e state_q;
  mcc_state_e state_d;
  logic       bad_q;
  logic       bad_d;

  always_comb begin
    state_d = next_step(state_q, cls);
    bad_d   = (state_q == S_DECODE) && (cls == C_BAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bad_q   <= bad_d;
    end
  end

  assign state  = state_q;
  assign bad_op = bad_q;

endmodule

// File: rtl/mcc_ctl_rom.sv
module mcc_ctl_rom
  import mcc_pkg::*;
(
  input  mcc_state_e state,
  output mcc_ctl_t   ctl
);

  always_comb ctl = ctl_of(state);

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int                   OPC_W     = 6,
  parameter logic [OPC_W-1:0]     OPC_RTYPE = 6'b000000,
  parameter logic [OPC_W-1:0]     OPC_LOAD  = 6'b100011,
  parameter logic [OPC_W-1:0]     OPC_STORE = 6'b101011,
  parameter logic [OPC_W-1:0]     OPC_BEQ   = 6'b000100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zero,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_we,
  output logic             reg_we,
  output logic             dst_sel,
  output logic             wb_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             pc_upd,
  output logic             pc_upd_cond,
  output logic             pc_src,
  output logic             pc_we,
  output logic             bad_op
);

  op_class_e           op_cls;
  mcc_state_e          state;
  mcc_ctl_t            ctl;
  logic [NUM_ST-1:0]   st_hot;

  mcc_opdecode #(
    .OW(OPC_W), .OPC_RTYPE(OPC_RTYPE), .OPC_LOAD(OPC_LOAD),
    .OPC_STORE(OPC_STORE), .OPC_BEQ(OPC_BEQ)
  ) u_dec (
    .opcode (opcode),
    .cls    (op_cls)
  );

  mcc_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .cls    (op_cls),
    .state  (state),
    .bad_op (bad_op)
  );

  mcc_ctl_rom u_rom (
    .state (state),
    .ctl   (ctl)
  );

  // One-hot view of the step, brought out for the checker
  for (genvar i = 0; i < NUM_ST; i++) begin : g_hot
    assign st_hot[i] = (state == mcc_state_e'(i));
  end

  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
  assign addr_sel    = ctl.addr_sel;
  assign ir_we       = ctl.ir_we;
  assign reg_we      = ctl.reg_we;
  assign dst_sel     = ctl.dst_sel;
  assign wb_sel      = ctl.wb_sel;
  assign alu_a_sel   = ctl.alu_a_sel;
  assign alu_b_sel   = ctl.alu_b_sel;
  assign alu_op      = ctl.alu_op;
  assign pc_upd      = ctl.pc_upd;
  assign pc_upd_cond = ctl.pc_upd_cond;
  assign pc_src      = ctl.pc_src;
  assign pc_we       = pc_enable(ctl.pc_upd, ctl.pc_upd_cond, zero);

endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
  parameter int               OW        = 6,
  parameter logic [OW-1:0]    OPC_LOAD  = 6'b100011,
  parameter logic [OW-1:0]    OPC_STORE = 6'b101011,
  parameter int               NS        = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [OW-1:0] opcode,
  input logic          zero,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          addr_sel,
  input logic          ir_we,
  input logic          reg_we,
  input logic          dst_sel,
  input logic          wb_sel,
  input logic [1:0]    alu_op,
  input logic          pc_upd,
  input logic          pc_upd_cond,
  input logic          pc_src,
  input logic          pc_we,
  input logic          bad_op,
  input logic [NS-1:0] st_hot
);

  assert_reset_fetch_R1: assert property (@(posedge clk)
    rst |=> (ir_we && mem_rd && pc_upd && !bad_op));

  assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (rst)
    st_hot[0] |=> st_hot[1]);

  assert_dispatch_mem_R3: assert property (@(posedge clk) disable iff (rst)
    (st_hot[1] && (opcode == OPC_LOAD || opcode == OPC_STORE)) |=> st_hot[2]);

  assert_addr_load_R4: assert property (@(posedge clk) disable iff (rst)
    (st_hot[2] && opcode == OPC_LOAD) |=> (mem_rd && addr_sel));

  assert_load_wb_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (reg_we && wb_sel && !dst_sel));

  assert_store_done_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> st_hot[0]);

  assert_rexe_wb_R7: assert property (@(posedge clk) disable iff (rst)
    st_hot[6] |=> (reg_we && dst_sel && !wb_sel));

  assert_branch_R8: assert property (@(posedge clk) disable iff (rst)
    pc_upd_cond |-> (pc_src && alu_op == 2'd1 && !pc_upd));

  assert_onehot_step_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(st_hot) == 1);

  assert_no_mem_clash_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_bad_flag_R11: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> (st_hot[0] && $past(st_hot[1])));

  assert_pc_gate_R12: assert property (@(posedge clk) disable iff (rst)
    (!pc_upd && !(pc_upd_cond && zero)) |-> !pc_we);

endmodule

bind mcc_ctrl_fsm mcc_checker #(
  .OW(OPC_W), .OPC_LOAD(OPC_LOAD), .OPC_STORE(OPC_STORE), .NS(mcc_pkg::NUM_ST)
) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
  .reg_we(reg_we), .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_op(alu_op),
  .pc_upd(pc_upd), .pc_upd_cond(pc_upd_cond), .pc_src(pc_src),
  .pc_we(pc_we), .bad_op(bad_op), .st_hot(st_hot)
);

// File: tb/test_mcc_ctrl_fsm.sv
module test_mcc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       zero = 1'b0;
  logic mem_rd, mem_wr, addr_sel, ir_we, reg_we, dst_sel, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op;
  logic pc_upd, pc_upd_cond, pc_src, pc_we, bad_op;

  int n_chk = 0;
  int n_bad = 0;

  mcc_ctrl_fsm i_mcc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
    .reg_we(reg_we), .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_upd(pc_upd),
    .pc_upd_cond(pc_upd_cond), .pc_src(pc_src), .pc_we(pc_we), .bad_op(bad_op)
  );

  always #10 clk = ~clk;

  // Bench step numbering: 0 fetch,1 decode,2 addr,3 ld read,4 ld wb,
  // 5 st write,6 r exec,7 r wb,8 branch
  // Vector: rd wr iord irw rw dst mtr asrc bsrc[2] aop[2] pcw pcwc psrc
  function automatic logic [14:0] exp_vec(int s);
    case (s)
      0: return 15'b1001_000_0_01_00_100;
      1: return 15'b0000_000_0_11_00_000;
      2: return 15'b0000_000_1_10_00_000;
      3: return 15'b1010_000_0_00_00_000;
      4: return 15'b0000_101_0_00_00_000;
      5: return 15'b0110_000_0_00_00_000;
      6: return 15'b0000_000_1_00_10_000;
      7: return 15'b0000_110_0_00_00_000;
      8: return 15'b0000_000_1_00_01_011;
      default: return 15'b0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2/R10";
      1: return "R3/R10";
      2: return "R4/R10";
      3, 4: return "R5/R10";
      5: return "R6/R10";
      6, 7: return "R7/R10";
      default: return "R8/R10";
    endcase
  endfunction

  // class: 0 rtype,1 load,2 store,3 branch,4 unknown
  function automatic int cls_of(logic [5:0] op);
    if (op == 6'h00) return 0;
    if (op == 6'h23) return 1;
    if (op == 6'h2b) return 2;
    if (op == 6'h04) return 3;
    return 4;
  endfunction

  function automatic int step_after(int s, int c);
    case (s)
      0: return 1;
      1: return (c == 1 || c == 2) ? 2 : (c == 0) ? 6 : (c == 3) ? 8 : 0;
      2: return (c == 1) ? 3 : 5;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int cycles_of(int c);
    case (c)
      0: return 4;
      1: return 5;
      2: return 4;
      3: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  logic [5:0] dir_ops [8];
  initial begin
    dir_ops[0] = 6'h00; dir_ops[1] = 6'h23; dir_ops[2] = 6'h2b;
    dir_ops[3] = 6'h04; dir_ops[4] = 6'h04; dir_ops[5] = 6'h3f;
    dir_ops[6] = 6'h23; dir_ops[7] = 6'h00;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int model_st;
    int exp_bad;
    int cyc;
    int cur_cls;
    int dir_idx;
    bit cnt_ok;
    bit just_rst;
    bit mid_rst_done;
    logic [14:0] act;
    void'($urandom(32'd7319));
    model_st = 0; exp_bad = 0; cyc = 0; cur_cls = 0; dir_idx = 0;
    cnt_ok = 0; just_rst = 1; mid_rst_done = 0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      rst = 1'b0;
      zero = 1'($urandom % 2);
      #1;
      act = {mem_rd, mem_wr, addr_sel, ir_we, reg_we, dst_sel, wb_sel,
             alu_a_sel, alu_b_sel, alu_op, pc_upd, pc_upd_cond, pc_src};
      chk(just_rst ? "R1" : tag_of(model_st), 32'(act), 32'(exp_vec(model_st)));
      chk("R11", 32'(bad_op), 32'(exp_bad));
      // R12: combined PC write from the expected update lines and zero
      chk("R12", 32'(pc_we), 32'((model_st == 0) || (model_st == 8 && zero)));
      if (model_st == 0) begin
        if (cnt_ok) chk("R9", 32'(cyc), 32'(cycles_of(cur_cls)));
        cyc = 1;
        cnt_ok = 1;
      end else begin
        cyc++;
      end
      if (model_st == 1) cur_cls = cls_of(opcode);
      just_rst = 0;
      if (!mid_rst_done && n > 400 && model_st == 3) begin
        rst = 1'b1;
        mid_rst_done = 1;
      end
      if (rst) begin
        exp_bad = 0;
        cnt_ok = 0;
        just_rst = 1;
        if (model_st == 0) model_st = -1;
      end else begin
        exp_bad = (model_st == 1 && cls_of(opcode) == 4) ? 1 : 0;
      end
      if (model_st == 0 || model_st == -1) begin
        if (dir_idx < 8) begin
          opcode = dir_ops[dir_idx];
          dir_idx++;
        end else begin
          case ($urandom % 10)
            0, 1: opcode = 6'h00;
            2, 3: opcode = 6'h23;
            4, 5: opcode = 6'h2b;
            6, 7: opcode = 6'h04;
            default: opcode = 6'($urandom);
          endcase
        end
      end
      model_st = rst ? 0 : step_after(model_st, cls_of(opcode));
    end
    finish_run();
  end

endmodule